// File: doc/BRIEF.md
# Exception Entry State Sequencer

This block performs the architectural register update that a 64-bit core makes when it takes a synchronous exception. A single-cycle take strobe presents the cause, a sub-reason, a store flag, the current instruction address, the faulting effective address and the current machine state word. On the following clock edge the block registers several values in one step: the new machine state word, the saved return address, the saved-state word, the fault status and fault address registers, and the address at which fetch resumes. A one-cycle completion pulse accompanies them, and a double-exception flag is raised when the core was not in a recoverable state.

The saved return address, saved-state, fault status and fault address registers can also be written through a simple load port, which is used to set up state for tests. Bit positions below are given as hardware bit indices, with bit 63 the most significant bit of a 64-bit word and bit 31 the most significant bit of the 32-bit status.

Top module: `exc_entry_seq`

## Requirements
- R1: On a take, the new machine state equals the old state with bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared and bit 63 forced to 1. All other bits are copied unchanged.
- R2: On a take, the saved-state word equals the old machine state ANDed with 64'hFFFF_FFFF_87C0_FFFF, ORed with the reason bits that R6 and R7 define (zero for all other causes).
- R3: The cause code is: 0 machine check, 1 data storage, 2 instruction storage, 3 alignment, 4 program, 5 FP unavailable, 6 system call, 7 FP assist. The cause codes select the offsets 0x200, 0x300, 0x400, 0x600, 0x700, 0x800, 0xC00 and 0xE00 in that order. The fetch address is the offset ORed with 64'hFFFF_FFFF_FFF0_0000 when bit 6 of the new machine state is 1, and is the offset alone otherwise.
- R4: The saved return address is the instruction address, or the instruction address plus 4 for a system call.
- R5: On a data storage take, the fault address is the effective address. The status is one reason bit ORed with 32'h0200_0000 when the store flag is 1. Reasons: 0 direct-store error 32'h8000_0000, 1 table miss 32'h4000_0000, 2 protection 32'h0800_0000, 3 external-access violation 32'h0010_0000, 4 segment miss 32'h0020_0000, 5 external-access disabled 32'h0008_0000. Reasons 6 and 7 add no reason bit.
- R6: On an instruction storage take, the reason goes into the saved-state word and not into the status: 0 table miss bit 30, 1 direct-store bit 28, 2 protection bit 27, 3 segment miss bit 21.
- R7: On a program take, exactly one saved-state bit is set: 0 FP-enabled bit 20, 1 illegal bit 19, 2 privileged bit 18, 3 trap bit 17, 4 unsupported optional instruction bit 19.
- R8: On an alignment take, the fault address is the effective address and the status becomes zero, whatever the store flag is.
- R9: Takes of any cause other than data storage and alignment leave the fault status and fault address unchanged.
- R10: When bit 1 of the old machine state is 0 at a take, the double-exception flag is 1 together with the completion pulse. The full register update still takes place.
- R11: All outputs change on the clock edge after the take strobe. The completion pulse lasts exactly one cycle and appears only after a take.
- R12: When the load enable is 1 and no take occurs, the selected register receives the load data: 0 return address, 1 saved-state, 2 status (low 32 bits of the data), 3 fault address. A load produces no completion pulse, and a take in the same cycle overrides the load.
- R13: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | One-cycle exception take strobe |
| cause_i | input | 3 | Exception cause code |
| reason_i | input | 3 | Sub-reason within the cause |
| store_i | input | 1 | Faulting access was a store |
| cia_i | input | 64 | Current instruction address |
| ea_i | input | 64 | Faulting effective address |
| msr_i | input | 64 | Current machine state word |
| ld_en_i | input | 1 | Test-setup load enable |
| ld_sel_i | input | 2 | Register selected for load |
| ld_data_i | input | 64 | Load data |
| msr_o | output | 64 | New machine state word |
| ret_o | output | 64 | Saved return address |
| saved_o | output | 64 | Saved-state word |
| status_o | output | 32 | Fault status register |
| fault_addr_o | output | 64 | Fault address register |
| fetch_o | output | 64 | Next fetch address |
| done_o | output | 1 | One-cycle completion pulse |
| dbl_err_o | output | 1 | Double-exception flag |

## Verification
A vector table runs through every cause and every listed sub-reason, including the external-access, segment-miss and optional-instruction cases. It alternates two machine-state words: one has the prefix bit set and dense ones across masked and cleared positions, the other has the prefix bit clear and a sparse pattern. This separates the two vector bases and shows which bits the saved-state mask keeps. Store and load flags vary within the data storage and alignment rows, so a status bit that leaks from the store flag becomes visible. Other causes interleave with the fault-producing ones, so a status or address that is not held shows up as a mismatch. Directed cases then cover the non-recoverable take, a take that collides with a load, load-only writes that must not pulse completion, and reasons that have no encoding.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XLEN = 64;
  localparam int SLEN = 32;

  typedef enum logic [2:0] {
    CS_MCHK    = 3'd0,
    CS_DSTOR   = 3'd1,
    CS_ISTOR   = 3'd2,
    CS_ALIGN   = 3'd3,
    CS_PROG    = 3'd4,
    CS_FPUNAV  = 3'd5,
    CS_SYSCALL = 3'd6,
    CS_FPASST  = 3'd7
  } cause_e;

  // Machine state positions, architectural (MSB = 0) numbering
  localparam int MP_WIDE  = 0;
  localparam int MP_PWR   = 45;
  localparam int MP_EXTEN = 48;
  localparam int MP_USER  = 49;
  localparam int MP_FPAV  = 50;
  localparam int MP_FEM0  = 52;
  localparam int MP_STEP  = 53;
  localparam int MP_BRTR  = 54;
  localparam int MP_FEM1  = 55;
  localparam int MP_PFX   = 57;
  localparam int MP_IXLT  = 58;
  localparam int MP_DXLT  = 59;
  localparam int MP_RCV   = 62;

  function automatic logic [XLEN-1:0] bit64(input int n);
    return 64'(1) << (XLEN - 1 - n);
  endfunction

  function automatic logic [SLEN-1:0] bit32(input int n);
    return 32'(1) << (SLEN - 1 - n);
  endfunction

  function automatic logic [XLEN-1:0] span64(input int lo, input int hi);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < XLEN; i++)
      if (i >= lo && i <= hi) m |= bit64(i);
    return m;
  endfunction

  localparam logic [XLEN-1:0] MS_CLEAR =
    bit64(MP_PWR) | bit64(MP_EXTEN) | bit64(MP_USER) | bit64(MP_FPAV) |
    bit64(MP_FEM0) | bit64(MP_STEP) | bit64(MP_BRTR) | bit64(MP_FEM1) |
    bit64(MP_IXLT) | bit64(MP_DXLT) | bit64(MP_RCV);

  localparam logic [XLEN-1:0] SS_KEEP  = span64(48, 63) | span64(37, 41) | span64(0, 32);
  localparam logic [XLEN-1:0] VEC_HIGH = span64(0, 43);

  // Hardware index of the recoverable and prefix bits
  localparam int HW_RCV = XLEN - 1 - MP_RCV;
  localparam int HW_PFX = XLEN - 1 - MP_PFX;
  localparam int HW_WIDE = XLEN - 1 - MP_WIDE;

  function automatic logic [11:0] vec_offset(input cause_e c);
    case (c)
      CS_MCHK:    return 12'h200;
      CS_DSTOR:   return 12'h300;
      CS_ISTOR:   return 12'h400;
      CS_ALIGN:   return 12'h600;
      CS_PROG:    return 12'h700;
      CS_FPUNAV:  return 12'h800;
      CS_SYSCALL: return 12'hC00;
      default:    return 12'hE00;
    endcase
  endfunction

endpackage

// File: rtl/exc_reason_enc.sv
module exc_reason_enc
  import exc_pkg::*;
#(
  parameter int RSN_W = 3
) (
  input  cause_e            cause,
  input  logic [RSN_W-1:0]  reason,
  input  logic              is_store,
  output logic [XLEN-1:0]   ss_bits,
  output logic [SLEN-1:0]   st_val,
  output logic              st_wr,
  output logic              fa_wr
);

  // Status bit positions (MSB = 0 on the 32-bit status)
  localparam int SP_DIRECT = 0;
  localparam int SP_MISS   = 1;
  localparam int SP_PROT   = 4;
  localparam int SP_STORE  = 6;
  localparam int SP_SEGM   = 10;
  localparam int SP_XVIOL  = 11;
  localparam int SP_XDIS   = 12;

  logic [SLEN-1:0] dstor_rsn;
  logic [XLEN-1:0] istor_rsn;
  logic [XLEN-1:0] prog_rsn;

  always_comb begin
    case (reason)
      RSN_W'(0): dstor_rsn = bit32(SP_DIRECT);
      RSN_W'(1): dstor_rsn = bit32(SP_MISS);
      RSN_W'(2): dstor_rsn = bit32(SP_PROT);
      RSN_W'(3): dstor_rsn = bit32(SP_XVIOL);
      RSN_W'(4): dstor_rsn = bit32(SP_SEGM);
      RSN_W'(5): dstor_rsn = bit32(SP_XDIS);
      default:   dstor_rsn = '0;
    endcase
  end

  always_comb begin
    case (reason)
      RSN_W'(0): istor_rsn = bit64(33);
      RSN_W'(1): istor_rsn = bit64(35);
      RSN_W'(2): istor_rsn = bit64(36);
      RSN_W'(3): istor_rsn = bit64(42);
      default:   istor_rsn = '0;
    endcase
  end

  always_comb begin
    case (reason)
      RSN_W'(0): prog_rsn = bit64(43);
      RSN_W'(1),
      RSN_W'(4): prog_rsn = bit64(44);
      RSN_W'(2): prog_rsn = bit64(45);
      RSN_W'(3): prog_rsn = bit64(46);
      default:   prog_rsn = '0;
    endcase
  end

  always_comb begin
    ss_bits = '0;
    st_val  = '0;
    st_wr   = 1'b0;
    fa_wr   = 1'b0;
    case (cause)
      CS_DSTOR: begin
        st_val = dstor_rsn | (is_store ? bit32(SP_STORE) : '0);
        st_wr  = 1'b1;
        fa_wr  = 1'b1;
      end
      CS_ALIGN: begin
        st_wr = 1'b1;
        fa_wr = 1'b1;
      end
      CS_ISTOR: ss_bits = istor_rsn;
      CS_PROG:  ss_bits = prog_rsn;
      default: ;
    endcase
  end

  always_comb begin
    if (cause == CS_PROG || cause == CS_ISTOR)
      AST_ONE_REASON: assert ($countones(ss_bits) <= 1) else $error("multiple reason bits"); // R7
  end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
(
  input  cause_e           cause,
  input  logic [XLEN-1:0]  msr_old,
  input  logic [XLEN-1:0]  ss_bits,
  output logic [XLEN-1:0]  msr_new,
  output logic [XLEN-1:0]  ss_new,
  output logic [XLEN-1:0]  fetch
);

  logic [XLEN-1:0] base;

  always_comb begin
    msr_new = (msr_old & ~MS_CLEAR) | bit64(MP_WIDE);
    ss_new  = (msr_old & SS_KEEP) | ss_bits;
    base    = msr_new[HW_PFX] ? VEC_HIGH : '0;
    fetch   = base | XLEN'(vec_offset(cause));
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int RSN_W       = 3,
  parameter int SYS_STEP    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [2:0]        cause_i,
  input  logic [RSN_W-1:0]  reason_i,
  input  logic              store_i,
  input  logic [63:0]       cia_i,
  input  logic [63:0]       ea_i,
  input  logic [63:0]       msr_i,
  input  logic              ld_en_i,
  input  logic [1:0]        ld_sel_i,
  input  logic [63:0]       ld_data_i,
  output logic [63:0]       msr_o,
  output logic [63:0]       ret_o,
  output logic [63:0]       saved_o,
  output logic [31:0]       status_o,
  output logic [63:0]       fault_addr_o,
  output logic [63:0]       fetch_o,
  output logic              done_o,
  output logic              dbl_err_o
);

  localparam logic [1:0] LD_RET = 2'd0;
  localparam logic [1:0] LD_SS  = 2'd1;
  localparam logic [1:0] LD_ST  = 2'd2;
  localparam logic [1:0] LD_FA  = 2'd3;

  // Reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  cause_e          cause;
  logic [XLEN-1:0] ss_bits, msr_calc, ss_calc, fetch_calc;
  logic [SLEN-1:0] st_val;
  logic            st_wr, fa_wr;

  assign cause = cause_e'(cause_i);

  exc_reason_enc #(.RSN_W(RSN_W)) u_enc (
    .cause    (cause),
    .reason   (reason_i),
    .is_store (store_i),
    .ss_bits  (ss_bits),
    .st_val   (st_val),
    .st_wr    (st_wr),
    .fa_wr    (fa_wr)
  );

  exc_state_calc u_calc (
    .cause   (cause),
    .msr_old (msr_i),
    .ss_bits (ss_bits),
    .msr_new (msr_calc),
    .ss_new  (ss_calc),
    .fetch   (fetch_calc)
  );

  logic [XLEN-1:0] msr_n, ret_n, ss_n, fa_n, fetch_n;
  logic [SLEN-1:0] st_n;
  logic            done_n, dbl_n;

  always_comb begin
    msr_n   = msr_o;
    ret_n   = ret_o;
    ss_n    = saved_o;
    st_n    = status_o;
    fa_n    = fault_addr_o;
    fetch_n = fetch_o;
    done_n  = 1'b0;
    dbl_n   = 1'b0;
    if (take_i) begin
      msr_n   = msr_calc;
      ss_n    = ss_calc;
      fetch_n = fetch_calc;
      ret_n   = (cause == CS_SYSCALL) ? cia_i + XLEN'(SYS_STEP) : cia_i;
      if (st_wr) st_n = st_val;
      if (fa_wr) fa_n = ea_i;
      done_n  = 1'b1;
      dbl_n   = ~msr_i[HW_RCV];
    end else if (ld_en_i) begin
      case (ld_sel_i)
        LD_RET:  ret_n = ld_data_i;
        LD_SS:   ss_n  = ld_data_i;
        LD_ST:   st_n  = ld_data_i[SLEN-1:0];
        LD_FA:   fa_n  = ld_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      msr_o        <= '0;
      ret_o        <= '0;
      saved_o      <= '0;
      status_o     <= '0;
      fault_addr_o <= '0;
      fetch_o      <= '0;
      done_o       <= 1'b0;
      dbl_err_o    <= 1'b0;
    end else begin
      msr_o        <= msr_n;
      ret_o        <= ret_n;
      saved_o      <= ss_n;
      status_o     <= st_n;
      fault_addr_o <= fa_n;
      fetch_o      <= fetch_n;
      done_o       <= done_n;
      dbl_err_o    <= dbl_n;
    end
  end

  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_q_n)
    take_i |=> done_o) else $error("no completion after take"); // R11
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !take_i |=> !done_o) else $error("completion without take"); // R11
  AST_WIDE_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |-> msr_o[HW_WIDE]) else $error("wide-mode bit not forced"); // R1
  AST_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (take_i && !msr_i[HW_RCV]) |=> dbl_err_o) else $error("double exception missed"); // R10
  AST_SYSCALL_RET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (take_i && cause_i == 3'd6) |=> (ret_o == $past(cia_i) + 64'(SYS_STEP))) else $error("syscall return"); // R4
  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (take_i && cause_i == 3'd3) |=> (status_o == '0)) else $error("alignment status"); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (take_i && cause_i != 3'd1 && cause_i != 3'd3) |=> ($stable(status_o) && $stable(fault_addr_o)))
    else $error("fault registers changed"); // R9

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  localparam logic [63:0] CLR_M  = 64'h0000_0000_0004_EF32;
  localparam logic [63:0] WIDE_B = 64'h8000_0000_0000_0000;
  localparam logic [63:0] KEEP_M = 64'hFFFF_FFFF_87C0_FFFF;
  localparam logic [63:0] HI_B   = 64'hFFFF_FFFF_FFF0_0000;
  localparam logic [63:0] MA     = 64'hA5A5_5A5A_F0F0_FFFF;
  localparam logic [63:0] MB     = 64'h0123_4567_89AB_CD02;

  typedef struct packed {
    logic [2:0]  cause;
    logic [2:0]  rsn;
    logic        st;
    logic [63:0] msr;
    logic [11:0] off;
    logic [63:0] ss_rsn;
    logic [31:0] status;
    logic        upd;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd0, 1'b0, MB, 12'h200, 64'h0,         32'h0,         1'b0},
    '{3'd1, 3'd0, 1'b1, MB, 12'h300, 64'h0,         32'h8200_0000, 1'b1},
    '{3'd1, 3'd1, 1'b0, MA, 12'h300, 64'h0,         32'h4000_0000, 1'b1},
    '{3'd5, 3'd0, 1'b0, MA, 12'h800, 64'h0,         32'h0,         1'b0},
    '{3'd1, 3'd2, 1'b1, MB, 12'h300, 64'h0,         32'h0A00_0000, 1'b1},
    '{3'd1, 3'd3, 1'b0, MA, 12'h300, 64'h0,         32'h0010_0000, 1'b1},
    '{3'd2, 3'd0, 1'b1, MB, 12'h400, 64'h4000_0000, 32'h0,         1'b0},
    '{3'd1, 3'd4, 1'b1, MB, 12'h300, 64'h0,         32'h0220_0000, 1'b1},
    '{3'd1, 3'd5, 1'b0, MA, 12'h300, 64'h0,         32'h0008_0000, 1'b1},
    '{3'd2, 3'd1, 1'b0, MA, 12'h400, 64'h1000_0000, 32'h0,         1'b0},
    '{3'd2, 3'd2, 1'b0, MB, 12'h400, 64'h0800_0000, 32'h0,         1'b0},
    '{3'd2, 3'd3, 1'b0, MA, 12'h400, 64'h0020_0000, 32'h0,         1'b0},
    '{3'd3, 3'd0, 1'b1, MB, 12'h600, 64'h0,         32'h0,         1'b1},
    '{3'd4, 3'd0, 1'b0, MA, 12'h700, 64'h0010_0000, 32'h0,         1'b0},
    '{3'd4, 3'd1, 1'b0, MB, 12'h700, 64'h0008_0000, 32'h0,         1'b0},
    '{3'd4, 3'd2, 1'b0, MA, 12'h700, 64'h0004_0000, 32'h0,         1'b0},
    '{3'd4, 3'd3, 1'b0, MB, 12'h700, 64'h0002_0000, 32'h0,         1'b0},
    '{3'd4, 3'd4, 1'b0, MA, 12'h700, 64'h0008_0000, 32'h0,         1'b0},
    '{3'd6, 3'd0, 1'b0, MB, 12'hC00, 64'h0,         32'h0,         1'b0},
    '{3'd7, 3'd0, 1'b0, MA, 12'hE00, 64'h0,         32'h0,         1'b0}
  };

  logic        clk, rst_n, take_i, store_i, ld_en_i, done_o, dbl_err_o;
  logic [2:0]  cause_i, reason_i;
  logic [1:0]  ld_sel_i;
  logic [63:0] cia_i, ea_i, msr_i, ld_data_i;
  logic [63:0] msr_o, ret_o, saved_o, fault_addr_o, fetch_o;
  logic [31:0] status_o;

  int n_chk, n_fail;

  exc_entry_seq u_dut (
    .clk (clk), .rst_n (rst_n), .take_i (take_i), .cause_i (cause_i),
    .reason_i (reason_i), .store_i (store_i), .cia_i (cia_i), .ea_i (ea_i),
    .msr_i (msr_i), .ld_en_i (ld_en_i), .ld_sel_i (ld_sel_i), .ld_data_i (ld_data_i),
    .msr_o (msr_o), .ret_o (ret_o), .saved_o (saved_o), .status_o (status_o),
    .fault_addr_o (fault_addr_o), .fetch_o (fetch_o), .done_o (done_o),
    .dbl_err_o (dbl_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic take(input logic [2:0] c, input logic [2:0] r, input logic s,
                      input logic [63:0] cia, input logic [63:0] ea, input logic [63:0] m);
    @(negedge clk);
    take_i = 1'b1; cause_i = c; reason_i = r; store_i = s;
    cia_i = cia; ea_i = ea; msr_i = m;
    @(negedge clk);
    take_i = 1'b0; ld_en_i = 1'b0;
  endtask

  task automatic load(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_data_i = d;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] m_st, m_fa, cia, ea;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; take_i = 1'b0; cause_i = '0; reason_i = '0; store_i = 1'b0;
    cia_i = '0; ea_i = '0; msr_i = '0; ld_en_i = 1'b0; ld_sel_i = '0; ld_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R13 msr", msr_o, 64'h0);
    chk("R13 fetch", fetch_o, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 status", {32'h0, status_o}, 64'h0);
    chk("R13 ret", ret_o, 64'h0);
    chk("R13 done", {63'h0, done_o}, 64'h0);

    m_st = 64'h0; m_fa = 64'h0;
    for (int i = 0; i < NVEC; i++) begin
      cia = 64'h0000_00C0_0000_1000 + 64'(i * 64);
      ea  = 64'hDEAD_0000_0BAD_F00D ^ (64'(i) << 36);
      take(VECS[i].cause, VECS[i].rsn, VECS[i].st, cia, ea, VECS[i].msr);
      if (VECS[i].upd) begin m_st = {32'h0, VECS[i].status}; m_fa = ea; end
      chk($sformatf("R1 v%0d msr", i), msr_o, (VECS[i].msr & ~CLR_M) | WIDE_B);
      chk($sformatf("R2 R6 R7 v%0d saved", i), saved_o, (VECS[i].msr & KEEP_M) | VECS[i].ss_rsn);
      chk($sformatf("R3 v%0d fetch", i), fetch_o,
          (VECS[i].msr[6] ? HI_B : 64'h0) | 64'(VECS[i].off));
      chk($sformatf("R4 v%0d ret", i), ret_o, cia + ((VECS[i].cause == 3'd6) ? 64'd4 : 64'd0));
      chk($sformatf("R5 R8 R9 v%0d status", i), {32'h0, status_o}, m_st);
      chk($sformatf("R5 R8 R9 v%0d addr", i), fault_addr_o, m_fa);
      chk($sformatf("R11 v%0d done", i), {63'h0, done_o}, 64'h1);
      chk($sformatf("R10 v%0d no dbl", i), {63'h0, dbl_err_o}, 64'h0);
      @(negedge clk);
      chk($sformatf("R11 v%0d done drops", i), {63'h0, done_o}, 64'h0);
    end

    // R10: non-recoverable take still updates
    take(3'd0, 3'd0, 1'b0, 64'h4000, 64'h0, 64'h0000_0000_0000_8000);
    chk("R10 dbl", {63'h0, dbl_err_o}, 64'h1);
    chk("R10 msr", msr_o, WIDE_B);
    chk("R10 ret", ret_o, 64'h4000);
    chk("R10 fetch", fetch_o, 64'h200);

    // R5: unencoded reason with store flag
    take(3'd1, 3'd7, 1'b1, 64'h5000, 64'h1234, MB);
    chk("R5 unlisted reason", {32'h0, status_o}, 64'h0200_0000);

    // R12: load-only writes, no completion
    load(2'd0, 64'h1111_2222_3333_4444);
    chk("R12 ret load", ret_o, 64'h1111_2222_3333_4444);
    chk("R12 no done", {63'h0, done_o}, 64'h0);
    load(2'd1, 64'h5555_6666_7777_8888);
    chk("R12 saved load", saved_o, 64'h5555_6666_7777_8888);
    load(2'd2, 64'hFFFF_FFFF_9ABC_DEF0);
    chk("R12 status load", {32'h0, status_o}, 64'h9ABC_DEF0);
    load(2'd3, 64'hCAFE_0000_0000_BEEF);
    chk("R12 addr load", fault_addr_o, 64'hCAFE_0000_0000_BEEF);

    // R9: fault registers kept after a non-fault cause following a load
    take(3'd5, 3'd0, 1'b0, 64'h6000, 64'h7777, MA);
    chk("R9 status kept", {32'h0, status_o}, 64'h9ABC_DEF0);
    chk("R9 addr kept", fault_addr_o, 64'hCAFE_0000_0000_BEEF);

    // R12: take overrides a simultaneous load
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = 2'd3; ld_data_i = 64'hBAD0_BAD0_BAD0_BAD0;
    take_i = 1'b1; cause_i = 3'd1; reason_i = 3'd2; store_i = 1'b0;
    cia_i = 64'h7000; ea_i = 64'h0000_0000_ABCD_0000; msr_i = MB;
    @(negedge clk);
    take_i = 1'b0; ld_en_i = 1'b0;
    chk("R12 take wins addr", fault_addr_o, 64'h0000_0000_ABCD_0000);
    chk("R12 take wins status", {32'h0, status_o}, 64'h0800_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule